// File: doc/BRIEF.md
# Fetch Sequence Predictor

This block sits beside the instruction fetch path. Each cycle the fetch PC indexes it, while the same PC goes to the instruction array. The block holds a direct-mapped, tagged table. An entry describes the run of instructions that starts at that PC: how many instructions fetch may take in one go (up to a parameter maximum, 16 by default), which of them are conditional branches predicted not taken, how the run ends, the branch target, and the cache way holding the target line. From the entry the block forms the PC for the next cycle in the same cycle. PCs count instructions, not bytes.

How the run ends decides the next PC. A run may simply fall through. A jump or a predicted-taken conditional goes to the stored target, and a conditional also raises a check request for a slower predictor. A call goes to its target and pushes its return address on a small circular return stack. A return pops that stack. A training port writes whole entries. It can also cut an entry at one of its interior branches, which then becomes the run's taken terminator. Runs are never allowed to cross a page, so fall-through fetch stops at page edges.

Top module: `seqPredictor`

## Requirements
- R1: After reset every table entry is empty and the return stack pointer is at slot 0 with all slots holding 0, so any lookup misses.
- R2: On a miss, or when lookupValid is low, predHit is 0, branchMask is 0, termKind is 0, wayHint is 0 and valReq is 0. nextPc is lookupPc+16, but never beyond the start of the next page (page = 1024 instructions). seqLen equals nextPc-lookupPc.
- R3: A lookup hits only when the slot (lookupPc mod 16) holds an entry trained at exactly lookupPc. On a hit, seqLen, branchMask (bit i = instruction at offset i is a not-taken branch), termKind and wayHint show the stored values.
- R4: termKind 0 (fall through): nextPc = lookupPc+seqLen.
- R5: termKind 3 (call): nextPc = stored target, and lookupPc+seqLen is pushed on the return stack at the clock edge.
- R6: termKind 4 (return): nextPc = most recently pushed value, and that value is popped at the clock edge. Push and pop never happen in the same cycle.
- R7: termKind 1 (conditional taken): nextPc = stored target, valReq = 1 and valPc = lookupPc+seqLen-1. No other kind raises valReq.
- R8: termKind 2 (jump): nextPc = stored target, and the return stack is untouched.
- R9: A write (trainOp 0) stores length 1 for a length of 0, and caps the length at 16 and at the distance to the page end. If the length was changed, termKind is stored as 0. Mask bits at or above the stored length are cleared.
- R10: A split (trainOp 1) at position p gives length p+1, keeps only mask bits below p, sets termKind 1, and stores the new target and way.
- R11: A split is ignored unless the slot holds an entry trained at trainPc, mask bit p of that entry is set, and p+1 is less than its length.
- R12: A write or split takes effect at the clock edge. A lookup of the same PC in that cycle sees the old contents.
- R13: With lookupValid low, the return stack and the validation request are left untouched.
- R14: The return stack holds 8 slots and wraps. After more than 8 pushes, the oldest values are overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Fetch PC is valid this cycle |
| lookupPc | input | 32 | Current fetch PC (instruction units) |
| predHit | output | 1 | Table hit |
| nextPc | output | 32 | PC for the next fetch cycle |
| seqLen | output | 5 | Instructions in this run |
| branchMask | output | 16 | Interior not-taken branch positions |
| termKind | output | 3 | 0 none, 1 cond, 2 jump, 3 call, 4 return |
| wayHint | output | 2 | Cache way of the target line |
| valReq | output | 1 | Validation request to the slow predictor |
| valPc | output | 32 | Address of the branch to validate |
| trainValid | input | 1 | Training operation this cycle |
| trainOp | input | 1 | 0 write, 1 split |
| trainPc | input | 32 | Start PC of the trained entry |
| trainLen | input | 5 | Run length for a write |
| trainMask | input | 16 | Not-taken branch mask for a write |
| trainKind | input | 3 | Terminator kind for a write |
| trainTarget | input | 32 | Target for a write or split |
| trainWay | input | 2 | Way hint for a write or split |
| trainPos | input | 4 | Split position |

## Verification
A training operation and a lookup of the same slot can fall in one cycle, and so can a call push and an entry rewrite. The bench drives a write or split on the very PC it is looking up. It expects the old descriptor in that cycle and the new one in the next. A long random phase mixes training, calls, returns and idle cycles over a small PC pool, including PCs near a page edge. Every output is compared each cycle against a behavioural model of the table and return stack.

// File: rtl/seqPredPkg.sv
package seqPredPkg;

  typedef enum logic [2:0] {
    TK_NONE = 3'd0,
    TK_COND = 3'd1,
    TK_JUMP = 3'd2,
    TK_CALL = 3'd3,
    TK_RET  = 3'd4
  } termKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tabWe;
    logic doSplit;
    logic rasPush;
    logic rasPop;
    logic valReq;
    logic selTarget;
    logic selRas;
  } ctlStrobes_t;

endpackage

// File: rtl/seqPredControl.sv
module seqPredControl
  import seqPredPkg::*;
#(
  parameter int LEN_W = 5,
  parameter int POS_W = 4
) (
  input  logic              lookupValid,
  input  logic              hitRaw,
  input  logic [2:0]        rdKind,
  input  logic              trainValid,
  input  logic              trainOp,
  input  logic [POS_W-1:0]  trainPos,
  input  logic              trainTagHit,
  input  logic [LEN_W-1:0]  trainOldLen,
  input  logic              trainPosBranch,
  output ctlStrobes_t       ctl
);

  logic active;
  logic splitOk;

  always_comb begin
    active  = lookupValid && hitRaw;
    splitOk = trainTagHit && trainPosBranch &&
              ((LEN_W'(trainPos) + LEN_W'(1)) < trainOldLen);

    ctl           = '0;
    ctl.tabWe     = trainValid && (!trainOp || splitOk);
    ctl.doSplit   = trainOp;
    ctl.rasPush   = active && (rdKind == TK_CALL);
    ctl.rasPop    = active && (rdKind == TK_RET);
    ctl.valReq    = active && (rdKind == TK_COND);
    ctl.selTarget = active && ((rdKind == TK_COND) || (rdKind == TK_JUMP) ||
                               (rdKind == TK_CALL));
    ctl.selRas    = active && (rdKind == TK_RET);
  end

endmodule

// File: rtl/seqPredDatapath.sv
module seqPredDatapath
  import seqPredPkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 16,
  parameter int MAX_LEN   = 16,
  parameter int RAS_DEPTH = 8,
  parameter int PAGE_SIZE = 1024,
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 5,
  parameter int POS_W     = 4,
  parameter int WAY_W     = 2,
  parameter int PAGE_W    = 10,
  parameter int RAS_PW    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic               lookupValid,
  input  logic [PC_W-1:0]    lookupPc,
  input  logic [PC_W-1:0]    trainPc,
  input  logic [LEN_W-1:0]   trainLen,
  input  logic [MAX_LEN-1:0] trainMask,
  input  logic [2:0]         trainKind,
  input  logic [PC_W-1:0]    trainTarget,
  input  logic [WAY_W-1:0]   trainWay,
  input  logic [POS_W-1:0]   trainPos,
  output logic               hitRaw,
  output logic [2:0]         rdKind,
  output logic               trainTagHit,
  output logic [LEN_W-1:0]   trainOldLen,
  output logic               trainPosBranch,
  output logic               predHit,
  output logic [PC_W-1:0]    nextPc,
  output logic [LEN_W-1:0]   seqLen,
  output logic [MAX_LEN-1:0] branchMask,
  output logic [2:0]         termKind,
  output logic [WAY_W-1:0]   wayHint,
  output logic [PC_W-1:0]    valPc
);

  localparam int TAG_W = PC_W - IDX_W;

  logic                validQ [ENTRIES];
  logic [TAG_W-1:0]    tagQ   [ENTRIES];
  logic [LEN_W-1:0]    lenQ   [ENTRIES];
  logic [MAX_LEN-1:0]  maskQ  [ENTRIES];
  logic [2:0]          kindQ  [ENTRIES];
  logic [PC_W-1:0]     tgtQ   [ENTRIES];
  logic [WAY_W-1:0]    wayQ   [ENTRIES];
  logic [PC_W-1:0]     rasQ   [RAS_DEPTH];
  logic [RAS_PW-1:0]   rasPtr;

  function automatic logic [MAX_LEN-1:0] lowMask(input logic [31:0] n);
    logic [MAX_LEN-1:0] m;
    for (int i = 0; i < MAX_LEN; i++) m[i] = (32'(i) < n);
    return m;
  endfunction

  // lookup side
  logic [IDX_W-1:0] lkIdx;
  logic [PC_W-1:0]  seqEnd, pageEnd, fallPc, missNext, rasTop;

  always_comb begin
    lkIdx    = lookupPc[IDX_W-1:0];
    hitRaw   = validQ[lkIdx] && (tagQ[lkIdx] == lookupPc[PC_W-1:IDX_W]);
    rdKind   = kindQ[lkIdx];
    seqEnd   = lookupPc + PC_W'(lenQ[lkIdx]);
    pageEnd  = {lookupPc[PC_W-1:PAGE_W], {PAGE_W{1'b0}}} + PC_W'(PAGE_SIZE);
    fallPc   = lookupPc + PC_W'(MAX_LEN);
    missNext = (fallPc[PC_W-1:PAGE_W] != lookupPc[PC_W-1:PAGE_W]) ? pageEnd : fallPc;
    rasTop   = rasQ[rasPtr - RAS_PW'(1)];
    predHit  = lookupValid && hitRaw;
    if (predHit) begin
      seqLen     = lenQ[lkIdx];
      branchMask = maskQ[lkIdx];
      termKind   = kindQ[lkIdx];
      wayHint    = wayQ[lkIdx];
    end else begin
      seqLen     = LEN_W'(missNext - lookupPc);
      branchMask = '0;
      termKind   = TK_NONE;
      wayHint    = '0;
    end
    valPc = seqEnd - PC_W'(1);
    if (ctl.selRas)         nextPc = rasTop;
    else if (ctl.selTarget) nextPc = tgtQ[lkIdx];
    else if (predHit)       nextPc = seqEnd;
    else                    nextPc = missNext;
  end

  // training side
  logic [IDX_W-1:0]   trIdx;
  logic [31:0]        lenIn, lenA, room, lenB;
  logic [LEN_W-1:0]   wrLen;
  logic [MAX_LEN-1:0] wrMask;
  logic [2:0]         wrKind;

  always_comb begin
    trIdx          = trainPc[IDX_W-1:0];
    trainTagHit    = validQ[trIdx] && (tagQ[trIdx] == trainPc[PC_W-1:IDX_W]);
    trainOldLen    = lenQ[trIdx];
    trainPosBranch = maskQ[trIdx][trainPos];
    lenIn = (trainLen == '0) ? 32'd1 : 32'(trainLen);
    lenA  = (lenIn > 32'(MAX_LEN)) ? 32'(MAX_LEN) : lenIn;
    room  = 32'(PAGE_SIZE) - 32'(trainPc[PAGE_W-1:0]);
    lenB  = (lenA > room) ? room : lenA;
    if (ctl.doSplit) begin
      wrLen  = LEN_W'(trainPos) + LEN_W'(1);
      wrMask = maskQ[trIdx] & lowMask(32'(trainPos));
      wrKind = TK_COND;
    end else begin
      wrLen  = LEN_W'(lenB);
      wrMask = trainMask & lowMask(lenB);
      wrKind = (lenB != lenIn) ? TK_NONE : trainKind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i] <= 1'b0; tagQ[i] <= '0; lenQ[i] <= '0; maskQ[i] <= '0;
        kindQ[i]  <= '0;   tgtQ[i] <= '0; wayQ[i] <= '0;
      end
    end else if (ctl.tabWe) begin
      validQ[trIdx] <= 1'b1;
      tagQ[trIdx]   <= trainPc[PC_W-1:IDX_W];
      lenQ[trIdx]   <= wrLen;
      maskQ[trIdx]  <= wrMask;
      kindQ[trIdx]  <= wrKind;
      tgtQ[trIdx]   <= trainTarget;
      wayQ[trIdx]   <= trainWay;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPtr <= '0;
      for (int i = 0; i < RAS_DEPTH; i++) rasQ[i] <= '0;
    end else if (ctl.rasPush) begin
      rasQ[rasPtr] <= seqEnd;
      rasPtr       <= rasPtr + RAS_PW'(1);
    end else if (ctl.rasPop) begin
      rasPtr <= rasPtr - RAS_PW'(1);
    end
  end

  // R6
  ras_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.rasPush, ctl.rasPop, ctl.valReq}));
  // R5
  push_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rasPush |=> (rasPtr == RAS_PW'($past(rasPtr) + RAS_PW'(1))));
  // R6
  pop_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rasPop |=> (rasPtr == RAS_PW'($past(rasPtr) - RAS_PW'(1))));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(ctl.rasPush || ctl.rasPop || ctl.valReq || ctl.selTarget || ctl.selRas));
  // R13
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> $stable(rasPtr));
  // R9
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitRaw |-> (lenQ[lkIdx] != '0) && (lenQ[lkIdx] <= LEN_W'(MAX_LEN)));
  // R7
  val_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.valReq |-> (predHit && termKind == TK_COND));

endmodule

// File: rtl/seqPredictor.sv
module seqPredictor
  import seqPredPkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 16,
  parameter int MAX_LEN   = 16,
  parameter int RAS_DEPTH = 8,
  parameter int WAYS      = 4,
  parameter int PAGE_SIZE = 1024,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int POS_W    = $clog2(MAX_LEN),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int PAGE_W   = $clog2(PAGE_SIZE),
  localparam int RAS_PW   = $clog2(RAS_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [PC_W-1:0]    lookupPc,
  output logic               predHit,
  output logic [PC_W-1:0]    nextPc,
  output logic [LEN_W-1:0]   seqLen,
  output logic [MAX_LEN-1:0] branchMask,
  output logic [2:0]         termKind,
  output logic [WAY_W-1:0]   wayHint,
  output logic               valReq,
  output logic [PC_W-1:0]    valPc,
  input  logic               trainValid,
  input  logic               trainOp,
  input  logic [PC_W-1:0]    trainPc,
  input  logic [LEN_W-1:0]   trainLen,
  input  logic [MAX_LEN-1:0] trainMask,
  input  logic [2:0]         trainKind,
  input  logic [PC_W-1:0]    trainTarget,
  input  logic [WAY_W-1:0]   trainWay,
  input  logic [POS_W-1:0]   trainPos
);

  ctlStrobes_t        ctl;
  logic               hitRaw, trainTagHit, trainPosBranch;
  logic [2:0]         rdKind;
  logic [LEN_W-1:0]   trainOldLen;

  seqPredControl #(.LEN_W(LEN_W), .POS_W(POS_W)) ctrl_i (
    .lookupValid(lookupValid), .hitRaw(hitRaw), .rdKind(rdKind),
    .trainValid(trainValid), .trainOp(trainOp), .trainPos(trainPos),
    .trainTagHit(trainTagHit), .trainOldLen(trainOldLen),
    .trainPosBranch(trainPosBranch), .ctl(ctl)
  );

  seqPredDatapath #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .RAS_DEPTH(RAS_DEPTH),
    .PAGE_SIZE(PAGE_SIZE), .IDX_W(IDX_W), .LEN_W(LEN_W), .POS_W(POS_W),
    .WAY_W(WAY_W), .PAGE_W(PAGE_W), .RAS_PW(RAS_PW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .lookupValid(lookupValid), .lookupPc(lookupPc),
    .trainPc(trainPc), .trainLen(trainLen), .trainMask(trainMask),
    .trainKind(trainKind), .trainTarget(trainTarget), .trainWay(trainWay),
    .trainPos(trainPos),
    .hitRaw(hitRaw), .rdKind(rdKind), .trainTagHit(trainTagHit),
    .trainOldLen(trainOldLen), .trainPosBranch(trainPosBranch),
    .predHit(predHit), .nextPc(nextPc), .seqLen(seqLen),
    .branchMask(branchMask), .termKind(termKind), .wayHint(wayHint),
    .valPc(valPc)
  );

  assign valReq = ctl.valReq;

endmodule

// File: tb/seqPredictor_tb_top.sv
module seqPredictor_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid;
  logic [31:0] lookupPc;
  logic        predHit;
  logic [31:0] nextPc;
  logic [4:0]  seqLen;
  logic [15:0] branchMask;
  logic [2:0]  termKind;
  logic [1:0]  wayHint;
  logic        valReq;
  logic [31:0] valPc;
  logic        trainValid, trainOp;
  logic [31:0] trainPc, trainTarget;
  logic [4:0]  trainLen;
  logic [15:0] trainMask;
  logic [2:0]  trainKind;
  logic [1:0]  trainWay;
  logic [3:0]  trainPos;

  always #5 clk = ~clk;

  seqPredictor dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .predHit(predHit), .nextPc(nextPc), .seqLen(seqLen), .branchMask(branchMask),
    .termKind(termKind), .wayHint(wayHint), .valReq(valReq), .valPc(valPc),
    .trainValid(trainValid), .trainOp(trainOp), .trainPc(trainPc),
    .trainLen(trainLen), .trainMask(trainMask), .trainKind(trainKind),
    .trainTarget(trainTarget), .trainWay(trainWay), .trainPos(trainPos)
  );

  // behavioural reference: slot contents keyed by slot, full PC stored
  bit          mVal  [16];
  int unsigned mPc   [16];
  int unsigned mLen  [16];
  int unsigned mMask [16];
  int unsigned mKind [16];
  int unsigned mTgt  [16];
  int unsigned mWay  [16];
  int unsigned ras   [8];
  int          rp;
  int          nCmp = 0;
  int          nBad = 0;
  string       ctxTag = "";

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", ctxTag, req, what, act, exp);
    end
  endtask

  task automatic step();
    int unsigned pc, idx, pageEnd, nx, L, k;
    bit hit;
    string req;
    pc  = lookupPc;
    idx = pc % 16;
    hit = lookupValid && mVal[idx] && (mPc[idx] == pc);
    #2;
    if (!hit) begin
      req = lookupValid ? "R2" : "R13";
      pageEnd = (pc / 1024 + 1) * 1024;
      nx = (pc + 16 > pageEnd) ? pageEnd : pc + 16;
      chk(req, "predHit", predHit, 0);
      chk(req, "nextPc", nextPc, nx);
      chk(req, "seqLen", seqLen, nx - pc);
      chk(req, "mask", branchMask, 0);
      chk(req, "kind", termKind, 0);
      chk(req, "way", wayHint, 0);
      chk(req, "valReq", valReq, 0);
    end else begin
      L = mLen[idx]; k = mKind[idx];
      chk("R3", "predHit", predHit, 1);
      chk("R3", "seqLen", seqLen, L);
      chk("R3", "mask", branchMask, mMask[idx]);
      chk("R3", "kind", termKind, k);
      chk("R3", "way", wayHint, mWay[idx]);
      case (k)
        0: begin chk("R4", "nextPc", nextPc, pc + L); chk("R4", "valReq", valReq, 0); end
        1: begin
             chk("R7", "nextPc", nextPc, mTgt[idx]);
             chk("R7", "valReq", valReq, 1);
             chk("R7", "valPc", valPc, pc + L - 1);
           end
        2: begin chk("R8", "nextPc", nextPc, mTgt[idx]); chk("R8", "valReq", valReq, 0); end
        3: begin chk("R5", "nextPc", nextPc, mTgt[idx]); chk("R5", "valReq", valReq, 0); end
        default: begin
             chk("R6", "nextPc", nextPc, ras[(rp + 7) % 8]);
             chk("R6", "valReq", valReq, 0);
           end
      endcase
    end
    @(posedge clk);
    if (hit && mKind[idx] == 3) begin ras[rp] = pc + mLen[idx]; rp = (rp + 1) % 8; end
    else if (hit && mKind[idx] == 4) rp = (rp + 7) % 8;
    if (trainValid) begin
      int unsigned ti, lenIn, a, room, b;
      ti = trainPc % 16;
      if (!trainOp) begin
        lenIn = (trainLen == 0) ? 1 : trainLen;
        a     = (lenIn > 16) ? 16 : lenIn;
        room  = 1024 - trainPc % 1024;
        b     = (a > room) ? room : a;
        mVal[ti] = 1; mPc[ti] = trainPc; mLen[ti] = b;
        mKind[ti] = (b != lenIn) ? 0 : trainKind;
        mMask[ti] = trainMask & ((1 << b) - 1);
        mTgt[ti] = trainTarget; mWay[ti] = trainWay;
      end else if (mVal[ti] && mPc[ti] == trainPc && trainPos + 1 < mLen[ti] &&
                   mMask[ti][trainPos]) begin
        mLen[ti] = trainPos + 1;
        mMask[ti] = mMask[ti] & ((1 << trainPos) - 1);
        mKind[ti] = 1; mTgt[ti] = trainTarget; mWay[ti] = trainWay;
      end
    end
    @(negedge clk);
  endtask

  task automatic setLook(bit v, int unsigned pc);
    lookupValid = v; lookupPc = pc;
  endtask

  task automatic setTrain(bit v, bit op, int unsigned pc, int unsigned len, int unsigned mask,
                          int unsigned kind, int unsigned tgt, int unsigned way, int unsigned pos);
    trainValid = v; trainOp = op; trainPc = pc; trainLen = 5'(len); trainMask = 16'(mask);
    trainKind = 3'(kind); trainTarget = tgt; trainWay = 2'(way); trainPos = 4'(pos);
  endtask

  task automatic wr(int unsigned pc, int unsigned len, int unsigned mask, int unsigned kind,
                    int unsigned tgt, int unsigned way);
    setLook(0, 0);
    setTrain(1, 0, pc, len, mask, kind, tgt, way, 0);
    step();
    setTrain(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic split(int unsigned pc, int unsigned pos, int unsigned tgt, int unsigned way);
    setLook(0, 0);
    setTrain(1, 1, pc, 0, 0, 0, tgt, way, pos);
    step();
    setTrain(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(int unsigned pc);
    setLook(1, pc);
    step();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finishRun();
  end

  initial begin
    int unsigned pool [12] = '{32'h40, 32'h41, 32'h50, 32'h51, 32'h60, 32'h3FC,
                               32'h3FD, 32'h7F0, 32'h7F8, 32'h1000, 32'h1010, 32'h1F};
    for (int i = 0; i < 16; i++) begin
      mVal[i] = 0; mPc[i] = 0; mLen[i] = 0; mMask[i] = 0; mKind[i] = 0; mTgt[i] = 0; mWay[i] = 0;
    end
    for (int i = 0; i < 8; i++) ras[i] = 0;
    rp = 0;
    rstN = 0;
    setLook(0, 0);
    setTrain(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: empty table after reset
    ctxTag = "R1";
    look(32'h100);
    look(32'h0);
    // R2: miss near a page edge stops at the page
    ctxTag = "R2";
    look(32'd1020);
    look(32'd1008);

    // R3 / R4: fall-through entry, then alias PC in same slot misses
    ctxTag = "R3";
    wr(32'h200, 10, 16'b0000_0000_0010_0100, 0, 0, 3);
    look(32'h200);
    look(32'h210);
    // R7 conditional with validation
    ctxTag = "R7";
    wr(32'h301, 6, 16'h0011, 1, 32'h5000, 2);
    look(32'h301);
    // R8 jump
    ctxTag = "R8";
    wr(32'h402, 3, 0, 2, 32'h800, 1);
    look(32'h402);
    // R5 / R6 call then return
    ctxTag = "R5";
    wr(32'h503, 4, 0, 3, 32'h904, 0);
    wr(32'h904, 2, 0, 4, 0, 1);
    look(32'h503);
    ctxTag = "R6";
    look(32'h904);

    // R9: page clamp, zero length, overlong length
    ctxTag = "R9";
    wr(32'h7F8, 12, 16'hFFFF, 3, 32'h1234, 2);
    look(32'h7F8);
    wr(32'h605, 0, 16'hFFFF, 2, 32'h777, 1);
    look(32'h605);
    wr(32'h606, 20, 16'hFFFF, 1, 32'h777, 1);
    look(32'h606);

    // R11: ignored splits on the 0x200 entry
    ctxTag = "R11";
    split(32'h200, 3, 32'hA00, 1);   // not a branch
    look(32'h200);
    split(32'h210, 5, 32'hA00, 1);   // tag mismatch
    look(32'h200);
    split(32'h301, 4, 32'hB00, 0);   // pos+1 not below length 6? 5<6 but bit4 set -> valid
    look(32'h301);
    split(32'h301, 0, 32'hB00, 0);   // pos 0 with length 5, bit0 set: valid split
    look(32'h301);
    split(32'h301, 0, 32'hC00, 3);   // now length 1: ignored
    look(32'h301);
    // R10: split 0x200 at position 5
    ctxTag = "R10";
    split(32'h200, 5, 32'hA00, 1);
    look(32'h200);

    // R12: training the looked-up PC in the same cycle
    ctxTag = "R12";
    setLook(1, 32'h60A);
    setTrain(1, 0, 32'h60A, 5, 0, 2, 32'h1111, 1, 0);
    step();
    setTrain(1, 0, 32'h60A, 7, 1, 0, 0, 2, 0);
    step();
    setTrain(0, 0, 0, 0, 0, 0, 0, 0, 0);
    look(32'h60A);

    // R13: idle cycle on a call entry leaves the stack alone
    ctxTag = "R13";
    setLook(0, 32'h503);
    step();
    look(32'h904);

    // R14: ten calls then ten returns around the 8-slot stack
    ctxTag = "R14";
    for (int k = 0; k < 10; k++) wr(32'h2000 + k, 1, 0, 3, 32'h3000, 0);
    wr(32'h200F, 1, 0, 4, 0, 0);
    for (int k = 0; k < 10; k++) look(32'h2000 + k);
    for (int k = 0; k < 10; k++) look(32'h200F);

    // mixed random traffic
    ctxTag = "RND";
    for (int n = 0; n < 2000; n++) begin
      setLook(1'($urandom_range(0, 3) != 0), pool[$urandom_range(0, 11)]);
      if ($urandom_range(0, 1) == 1)
        setTrain(1, 1'($urandom_range(0, 2) == 0), pool[$urandom_range(0, 11)],
                 $urandom_range(0, 20), $urandom_range(0, 65535), $urandom_range(0, 4),
                 pool[$urandom_range(0, 11)], $urandom_range(0, 3), $urandom_range(0, 15));
      else
        setTrain(0, 0, 0, 0, 0, 0, 0, 0, 0);
      step();
    end

    finishRun();
  end

endmodule